// File: doc/BRIEF.md
# Phase-Offset Cosine NCO

This block is a numerically controlled oscillator that emits one 10-bit cosine amplitude word per sample clock. A 48-bit phase accumulator advances by a frequency tuning word on every cycle and wraps modulo 2^48, so the output frequency is the tuning word times the sample rate divided by 2^48. A programmable 14-bit phase offset is added to the top of the accumulator. The top 12 bits of that sum then index a quarter-wave cosine table, and quadrant folding rebuilds the full cycle from it.

The result is coded in offset binary for a differential current-steering converter. The top code 1023 means cos = +1, code 0 means cos = -1, and codes 511 and 512 straddle the midscale point where both converter legs carry equal current. Software writes the tuning word and the offset into shadow registers. An update strobe moves both into the working registers at the same edge, so a frequency or phase change never shows half-written. A tuning word above 2^47 is clamped to 2^47 (the Nyquist limit) when it is applied.

Top module: `nco_cos_top`

## Requirements
- R1: The 48-bit accumulator adds the working tuning word at every clock edge outside reset and wraps modulo 2^48.
- R2: The output is the offset-binary cosine of phase index p = ((acc[47:34] + offset) mod 2^14) >> 2, over a 4096-step turn. It lies within one code of 511.5 + 511.5·cos(2π·p/4096). Code 1023 is +1 and code 0 is -1.
- R3: The output register follows the accumulator and offset state by one clock. A working tuning word of 0 holds the output constant.
- R4: wr_sel = 0 writes the tuning word from wr_data[47:0] and wr_sel = 1 writes the offset from wr_data[13:0], both into shadow registers. These writes change nothing at the output until upd is high at a clock edge. At that edge both working registers load together.
- R5: A shadow tuning word above 2^47 is applied as 2^47. A working word of exactly 2^47 makes the output alternate between 1023 and 0.
- R6: Synchronous reset clears the accumulator, the shadow registers and the working registers. The output reads 1023 during reset and in the first cycle after it.
- R7: The offset adds modulo 2^14 after the accumulator. With a tuning word of 0, an offset of 4096 gives a midscale code of 511 or 512, and an offset of 8192 gives code 0.
- R8: A register write in the same cycle as upd lands only in the shadow registers. It is applied at the next upd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Shadow register write enable |
| wr_sel | input | 1 | 0 selects the tuning word, 1 selects the phase offset |
| wr_data | input | 48 | Write data; the offset takes bits 13:0 |
| upd | input | 1 | Moves both shadow values into the working registers |
| amp_o | output | 10 | Offset-binary cosine amplitude |

## Verification
A wrong accumulator step or a wrong working tuning word shows at amp_o one cycle later, as a departure from the cosine trajectory that the bench predicts. Over a long sweep such an error grows into a gross mismatch within a few cycles. A broken quadrant fold or sign shows as an output mirrored about midscale as soon as the phase enters the affected quadrant. A shadow register that leaks before upd shows as a frequency or phase change on the cycle after the premature load.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_W = 48;
  localparam int OFF_W = 14;
  localparam int LUT_AW = 12;
  localparam int AMP_W = 10;

  typedef enum logic {
    SEL_FTW = 1'b0,
    SEL_OFF = 1'b1
  } wr_sel_e;

  // Clamp a tuning word to the half-range limit 2^(w-1).
  function automatic logic [ACC_W-1:0] clamp_ftw(input logic [ACC_W-1:0] v);
    logic [ACC_W-1:0] lim;
    lim = {1'b1, {(ACC_W-1){1'b0}}};
    return (v > lim) ? lim : v;
  endfunction

  // Quarter-wave magnitude: round(half_scale * cos(pi/2 * i / qsz)).
  function automatic logic [AMP_W-1:0] quarter_mag(input int i, input int qsz);
    real half;
    real ang;
    int  m;
    half = ((2.0 ** AMP_W) - 1.0) / 2.0;
    ang  = (3.14159265358979323846 / 2.0) * i / qsz;
    m    = $rtoi(half * $cos(ang) + 0.5);
    return AMP_W'(m);
  endfunction

  // Offset-binary code from a quarter magnitude and a sign.
  function automatic logic [AMP_W-1:0] ob_code(input logic [AMP_W-1:0] mag,
                                               input logic neg);
    logic [AMP_W-1:0] lo;
    logic [AMP_W-1:0] hi;
    lo = {1'b0, {(AMP_W-1){1'b1}}};
    hi = {1'b1, {(AMP_W-1){1'b0}}};
    return neg ? (hi - mag) : (lo + mag);
  endfunction
endpackage

// File: rtl/nco_cfg_regs.sv
module nco_cfg_regs #(
  parameter int ACC_W = nco_pkg::ACC_W,
  parameter int OFF_W = nco_pkg::OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             upd,
  output logic [ACC_W-1:0] ftw_sh,
  output logic [ACC_W-1:0] ftw_act,
  output logic [OFF_W-1:0] off_act
);
  logic [OFF_W-1:0] off_sh;
  logic             wr_ftw;
  logic             wr_off;

  assign wr_ftw = wr_en && (wr_sel == nco_pkg::SEL_FTW);
  assign wr_off = wr_en && (wr_sel == nco_pkg::SEL_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_sh <= '0;
      off_sh <= '0;
    end else begin
      if (wr_ftw) ftw_sh <= wr_data;
      if (wr_off) off_sh <= wr_data[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_act <= '0;
      off_act <= '0;
    end else if (upd) begin
      ftw_act <= nco_pkg::clamp_ftw(ftw_sh);
      off_act <= off_sh;
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W  = nco_pkg::ACC_W,
  parameter int OFF_W  = nco_pkg::OFF_W,
  parameter int LUT_AW = nco_pkg::LUT_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  ftw_act,
  input  logic [OFF_W-1:0]  off_act,
  output logic [ACC_W-1:0]  acc_q,
  output logic [LUT_AW-1:0] lut_addr
);
  localparam int DROP = OFF_W - LUT_AW;

  logic [OFF_W-1:0] ph_sum;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + ftw_act;
  end

  assign ph_sum   = acc_q[ACC_W-1 -: OFF_W] + off_act;
  assign lut_addr = ph_sum[OFF_W-1 -: LUT_AW];

  logic unused_ph_lo;
  assign unused_ph_lo = ^ph_sum[DROP-1:0];
endmodule

// File: rtl/nco_cos_rom.sv
module nco_cos_rom #(
  parameter int LUT_AW = nco_pkg::LUT_AW,
  parameter int AMP_W  = nco_pkg::AMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LUT_AW-1:0] lut_addr,
  output logic [AMP_W-1:0]  amp_q
);
  localparam int QAW = LUT_AW - 2;
  localparam int QSZ = 1 << QAW;

  logic [AMP_W-1:0] rom [0:QSZ];
  logic [1:0]       quad;
  logic [QAW-1:0]   frac;
  logic [QAW:0]     idx;
  logic             neg;
  logic [AMP_W-1:0] mag;
  logic [AMP_W-1:0] code;

  for (genvar g = 0; g <= QSZ; g++) begin : g_rom
    assign rom[g] = nco_pkg::quarter_mag(g, QSZ);
  end

  assign quad = lut_addr[LUT_AW-1 -: 2];
  assign frac = lut_addr[QAW-1:0];
  assign idx  = quad[0] ? ((QAW+1)'(QSZ) - {1'b0, frac}) : {1'b0, frac};
  assign neg  = quad[0] ^ quad[1];
  assign mag  = rom[idx];
  assign code = nco_pkg::ob_code(mag, neg);

  always_ff @(posedge clk) begin
    if (rst) amp_q <= '1;
    else     amp_q <= code;
  end
endmodule

// File: rtl/nco_cos_top.sv
module nco_cos_top #(
  parameter int ACC_W  = nco_pkg::ACC_W,
  parameter int OFF_W  = nco_pkg::OFF_W,
  parameter int LUT_AW = nco_pkg::LUT_AW,
  parameter int AMP_W  = nco_pkg::AMP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             upd,
  output logic [AMP_W-1:0] amp_o
);
  logic [ACC_W-1:0]  ftw_sh;
  logic [ACC_W-1:0]  ftw_act;
  logic [OFF_W-1:0]  off_act;
  logic [ACC_W-1:0]  acc_q;
  logic [LUT_AW-1:0] lut_addr;

  nco_cfg_regs #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd(upd), .ftw_sh(ftw_sh), .ftw_act(ftw_act), .off_act(off_act)
  );

  nco_phase_acc #(.ACC_W(ACC_W), .OFF_W(OFF_W), .LUT_AW(LUT_AW)) u_acc (
    .clk(clk), .rst(rst), .ftw_act(ftw_act), .off_act(off_act),
    .acc_q(acc_q), .lut_addr(lut_addr)
  );

  nco_cos_rom #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_rom (
    .clk(clk), .rst(rst), .lut_addr(lut_addr), .amp_q(amp_o)
  );
endmodule

// File: rtl/nco_cos_chk.sv
module nco_cos_chk #(
  parameter int ACC_W = nco_pkg::ACC_W,
  parameter int OFF_W = nco_pkg::OFF_W,
  parameter int AMP_W = nco_pkg::AMP_W
) (
  input logic             clk,
  input logic             rst,
  input logic             upd,
  input logic [ACC_W-1:0] acc_q,
  input logic [ACC_W-1:0] ftw_sh,
  input logic [ACC_W-1:0] ftw_act,
  input logic [OFF_W-1:0] off_act,
  input logic [AMP_W-1:0] amp_o
);
  localparam logic [ACC_W-1:0] LIM = {1'b1, {(ACC_W-1){1'b0}}};

  // R1: accumulator steps by the working word
  p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> acc_q == $past(acc_q) + $past(ftw_act));

  // R6: full-scale code in the first cycle after reset
  p_reset_full_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> amp_o == {AMP_W{1'b1}});

  // R4: working registers hold without an update
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(ftw_act) && $stable(off_act));

  // R5: applied word follows the shadow, clamped
  p_apply_r5: assert property (@(posedge clk) disable iff (rst)
    upd |=> ftw_act == (($past(ftw_sh) > LIM) ? LIM : $past(ftw_sh)));

  // R5: working word never exceeds half range
  p_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    ftw_act <= LIM);
endmodule

bind nco_cos_top nco_cos_chk #(.ACC_W(ACC_W), .OFF_W(OFF_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .upd(upd), .acc_q(acc_q), .ftw_sh(ftw_sh),
  .ftw_act(ftw_act), .off_act(off_act), .amp_o(amp_o)
);

// File: tb/sim_nco_cos_top.sv
`timescale 1ns/1ps
module sim_nco_cos_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [47:0] wr_data = '0;
  logic        upd = 1'b0;
  logic [9:0]  amp_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  nco_cos_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .upd(upd), .amp_o(amp_o)
  );

  // Behavioural model from the requirements, in real arithmetic
  localparam logic [47:0] HALF = 48'h8000_0000_0000;
  logic [47:0] m_acc, m_ftw, m_sf;
  logic [13:0] m_off, m_so;
  real         m_amp;

  function automatic real ideal(input logic [47:0] a, input logic [13:0] o);
    logic [13:0] s;
    real p;
    s = a[47:34] + o;
    p = real'(s >> 2) / 4096.0;
    return 511.5 + 511.5 * $cos(2.0 * 3.14159265358979323846 * p);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_acc <= '0; m_ftw <= '0; m_off <= '0; m_sf <= '0; m_so <= '0;
      m_amp <= 1023.0;
    end else begin
      m_amp <= ideal(m_acc, m_off);
      m_acc <= m_acc + m_ftw;
      if (wr_en && !wr_sel) m_sf <= wr_data;
      if (wr_en && wr_sel)  m_so <= wr_data[13:0];
      if (upd) begin
        m_ftw <= (m_sf > HALF) ? HALF : m_sf;
        m_off <= m_so;
      end
    end
  end

  task automatic chk_eq(input string tag, input int exp);
    total++;
    if (int'(amp_o) != exp) begin
      bad++;
      $display("FAIL %s: amp=%0d expected=%0d", tag, amp_o, exp);
    end
  endtask

  task automatic chk_model(input string tag);
    real d;
    total++;
    d = real'(amp_o) - m_amp;
    if (d > 1.0 || d < -1.0) begin
      bad++;
      $display("FAIL %s: amp=%0d expected=%f", tag, amp_o, m_amp);
    end
  endtask

  task automatic wr(input logic sel, input logic [47:0] d, input logic u);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; upd = u;
    @(negedge clk);
    wr_en = 1'b0; upd = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R6 during reset", 1023);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R6 first cycle after reset", 1023);
  endtask

  task automatic t_static();
    do_reset();
    repeat (5) begin
      @(negedge clk);
      chk_eq("R3 zero word holds output", 1023);
    end
    wr(1'b1, 48'd4096, 1'b1);  // R8: offset and update share a cycle
    repeat (2) @(negedge clk);
    chk_eq("R8 same-cycle write not applied", 1023);
    pulse_upd();
    @(negedge clk);
    total++;
    if (amp_o != 10'd511 && amp_o != 10'd512) begin
      bad++;
      $display("FAIL R7 quarter offset: amp=%0d expected=511or512", amp_o);
    end
    wr(1'b1, 48'd8192, 1'b0);
    pulse_upd();
    repeat (2) @(negedge clk);
    chk_eq("R7 half offset", 0);
    wr(1'b1, 48'd16384 + 48'd8192 + 48'd4096 * 2, 1'b0);  // 14-bit wrap: 0
    pulse_upd();
    repeat (2) @(negedge clk);
    chk_eq("R7 offset truncated to 14 bits", 1023);
  endtask

  task automatic t_shadow();
    do_reset();
    wr(1'b0, 48'h0123_4567_89AB, 1'b0);
    wr(1'b1, 48'd1000, 1'b0);
    repeat (6) begin
      @(negedge clk);
      chk_eq("R4 shadow write no effect", 1023);
    end
    pulse_upd();
    repeat (40) begin
      @(negedge clk);
      chk_model("R4 applied together");
    end
  endtask

  task automatic t_nyquist(input logic [47:0] w, input string tag);
    do_reset();
    wr(1'b0, w, 1'b0);
    pulse_upd();
    @(negedge clk);  // first step of accumulator reflected now
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk_eq(tag, (i % 2 == 0) ? 0 : 1023);
    end
  endtask

  task automatic t_sweep(input logic [47:0] w, input logic [13:0] o, input int n);
    do_reset();
    wr(1'b0, w, 1'b0);
    wr(1'b1, {34'd0, o}, 1'b0);
    pulse_upd();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_model("R1 R2 cosine trajectory");
    end
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(1'b0, HALF, 1'b1);  // R8: lands in shadow only
    repeat (4) begin
      @(negedge clk);
      chk_eq("R8 write with update held back", 1023);
    end
    pulse_upd();
    @(negedge clk);
    @(negedge clk);
    chk_eq("R8 applied at next update", 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: amp=%0d expected=finish", amp_o);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_static();
    t_shadow();
    t_nyquist(HALF, "R5 half-range alternates");
    t_nyquist(48'hFFFF_FFFF_FFFF, "R5 clamped word alternates");
    t_same_cycle();
    t_sweep(48'h0000_0A3D_70A3, 14'd0, 3000);
    t_sweep(48'h1234_5678_9ABC, 14'd3333, 500);
    t_sweep(48'h7FFF_0000_1111, 14'd12000, 300);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule